// File: doc/BRIEF.md
# PLL Divider Search Engine

This block chooses the settings of a phase-locked loop that multiplies a reference clock up to a serial lane bit rate. Software, or a sequencer, gives it the reference frequency and the wanted lane rate, both as integer kHz values, and pulses `start`. The engine steps through every allowed input divider N in ascending order. For each N it works out a feedback multiplier M and the resulting VCO frequency. It keeps the pair whose frequency lands nearest to the target.

Each N costs two long divisions. A single shared restoring divider does them, producing one quotient bit per clock. The first division gives the floor of target·N/Fref, which becomes M. The second gives the floor of M·Fref/N, which becomes the VCO frequency. Two more divisions at the start fix the range of N, and one at the end rounds the winning frequency up to whole Mbps. When the search ends, `done` pulses. The winning N, M, VCO frequency and Mbps rate then stay on the outputs, together with a found flag, until the next search is started.

Top module: `pll_div_search`

## Requirements
- R1: A `start` seen while idle captures `fref_khz` and `target_khz`. `busy` is high from the next cycle until the search ends, and `done` is high for exactly one cycle, with `busy` low. While `busy` is high, `start` pulses and input changes have no effect on the result, and they produce no extra `done`.
- R2: The candidates for N are every integer from max(1, ceil(Fref/40000)) to floor(Fref/5000), in ascending order. This keeps Fref/N between 5 MHz and 40 MHz.
- R3: For each N, M is floor(target·N/Fref). The candidate is dropped when that raw M is below 6 or above 512.
- R4: An odd M that passes R3 is raised by one, so a reported M is always even and lies within 6..512.
- R5: The candidate's VCO frequency is floor(M·Fref/N) kHz. The candidate is dropped unless this frequency lies within 80000..1500000 kHz inclusive.
- R6: Among the surviving candidates, the one with the smallest |target − VCO| wins. A later candidate replaces the stored one only when its error is strictly smaller, so on a tie the smaller N is kept.
- R7: If no candidate survives, `found` is 0 and `best_n`, `best_m`, `vco_khz` and `rate_mbps` are all 0 when `done` pulses.
- R8: `rate_mbps` is the winning VCO frequency divided by 1000 and rounded up.
- R9: After reset, `busy`, `done` and `found` are low and all result outputs are zero.
- R10: The results stay unchanged from `done` until the next accepted `start`, whatever happens on the operand inputs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Begin a search; sampled only while idle |
| fref_khz | input | FW | Reference frequency in kHz |
| target_khz | input | FW | Wanted lane rate in kHz |
| busy | output | 1 | Search in progress |
| done | output | 1 | One-cycle end-of-search strobe |
| found | output | 1 | A candidate satisfied every limit |
| best_n | output | FW | Chosen input divider |
| best_m | output | FW | Chosen (even) feedback multiplier |
| vco_khz | output | FW | Achieved VCO frequency in kHz |
| rate_mbps | output | FW | Achieved rate rounded up to Mbps |

## Verification
The search length depends on how many values of N the reference frequency allows. Every division takes 2·FW clocks. So the results become due in the same cycle as the `done` strobe, whose position varies, and not after a fixed delay. The bench therefore samples at falling edges, waits for `done`, and reads every result in that very cycle. It also checks that `done` has dropped one cycle later. A bench model predicts the results for a sweep of reference and target pairs, including ties, skipped multipliers and searches that find nothing. The hold and ignore checks watch the outputs over the tens of cycles that follow a disturbance.

// File: rtl/pll_div_search.sv
module pll_div_search #(
  parameter int FW            = 32,
  parameter int PFD_MIN_KHZ   = 5000,
  parameter int PFD_MAX_KHZ   = 40000,
  parameter int VCO_MIN_KHZ   = 80000,
  parameter int VCO_MAX_KHZ   = 1500000,
  parameter int M_MIN         = 6,
  parameter int M_MAX         = 512,
  parameter int RATE_UNIT_KHZ = 1000
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  input  logic [FW-1:0] fref_khz,
  input  logic [FW-1:0] target_khz,
  output logic          busy,
  output logic          done,
  output logic          found,
  output logic [FW-1:0] best_n,
  output logic [FW-1:0] best_m,
  output logic [FW-1:0] vco_khz,
  output logic [FW-1:0] rate_mbps
);
  localparam int PW = 2 * FW;
  localparam int CW = $clog2(PW + 1);

  typedef enum logic [2:0] {S_IDLE, S_NLO, S_NHI, S_MUL, S_VCO, S_RATE} st_t;

  st_t           st;
  logic          wait_q, done_q, found_q;
  logic [FW-1:0] fref_q, tgt_q, n_lo, n_hi, n_cur, m_cur, b_n, b_m, rate_q;
  logic [PW-1:0] b_vco, b_err;

  logic [PW-1:0] dq;
  logic [FW-1:0] rem, dvs;
  logic [CW-1:0] cnt;
  logic          drun;

  logic          go;
  logic [PW-1:0] g_dd;
  logic [FW-1:0] g_dv;

  wire [FW:0]    rem_sh = {rem, dq[PW-1]};
  wire           take   = rem_sh >= {1'b0, dvs};
  wire [FW:0]    sub    = rem_sh - {1'b0, dvs};
  wire           res_ok = wait_q && !drun;
  wire [PW-1:0]  tgt_w  = PW'(tgt_q);
  wire           m_ok   = dq >= PW'(M_MIN) && dq <= PW'(M_MAX);
  wire [PW-1:0]  m_even = dq + PW'(dq[0]);
  wire           vco_ok = dq >= PW'(VCO_MIN_KHZ) && dq <= PW'(VCO_MAX_KHZ);
  wire [PW-1:0]  err    = (dq > tgt_w) ? dq - tgt_w : tgt_w - dq;
  wire           accept = vco_ok && (!found_q || err < b_err);
  wire           last_n = n_cur == n_hi;

  assign busy      = st != S_IDLE;
  assign done      = done_q;
  assign found     = found_q;
  assign best_n    = b_n;
  assign best_m    = b_m;
  assign vco_khz   = b_vco[FW-1:0];
  assign rate_mbps = rate_q;

  always_comb begin
    go   = 1'b0;
    g_dd = '0;
    g_dv = '0;
    if (!wait_q) begin
      case (st)
        S_NLO:  begin go = 1'b1; g_dd = PW'(fref_q) + PW'(PFD_MAX_KHZ - 1); g_dv = FW'(PFD_MAX_KHZ); end
        S_NHI:  begin go = 1'b1; g_dd = PW'(fref_q); g_dv = FW'(PFD_MIN_KHZ); end
        S_MUL:  begin go = 1'b1; g_dd = tgt_w * PW'(n_cur); g_dv = fref_q; end
        S_VCO:  begin go = 1'b1; g_dd = PW'(m_cur) * PW'(fref_q); g_dv = n_cur; end
        S_RATE: begin go = 1'b1; g_dd = b_vco + PW'(RATE_UNIT_KHZ - 1); g_dv = FW'(RATE_UNIT_KHZ); end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dq <= '0; rem <= '0; dvs <= '0; cnt <= '0; drun <= 1'b0;
    end else if (go) begin
      dq <= g_dd; rem <= '0; dvs <= g_dv; cnt <= CW'(PW); drun <= 1'b1;
    end else if (drun) begin
      dq  <= {dq[PW-2:0], take};
      rem <= take ? sub[FW-1:0] : rem_sh[FW-1:0];
      cnt <= cnt - 1'b1;
      if (cnt == CW'(1)) drun <= 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st <= S_IDLE; wait_q <= 1'b0; done_q <= 1'b0; found_q <= 1'b0;
      fref_q <= '0; tgt_q <= '0; n_lo <= '0; n_hi <= '0; n_cur <= '0; m_cur <= '0;
      b_n <= '0; b_m <= '0; rate_q <= '0; b_vco <= '0; b_err <= '0;
    end else begin
      done_q <= 1'b0;
      if (go) wait_q <= 1'b1;
      case (st)
        S_IDLE: if (start) begin
          fref_q <= fref_khz; tgt_q <= target_khz;
          found_q <= 1'b0; b_n <= '0; b_m <= '0; b_vco <= '0; rate_q <= '0;
          b_err <= '1; wait_q <= 1'b0; st <= S_NLO;
        end
        S_NLO: if (res_ok) begin
          n_lo <= (dq == '0) ? FW'(1) : dq[FW-1:0];
          wait_q <= 1'b0; st <= S_NHI;
        end
        S_NHI: if (res_ok) begin
          n_hi <= dq[FW-1:0]; n_cur <= n_lo; wait_q <= 1'b0;
          if (dq == '0 || PW'(n_lo) > dq) begin
            st <= S_IDLE; done_q <= 1'b1;
          end else st <= S_MUL;
        end
        S_MUL: if (res_ok) begin
          wait_q <= 1'b0;
          if (m_ok) begin
            m_cur <= m_even[FW-1:0]; st <= S_VCO;
          end else if (!last_n) begin
            n_cur <= n_cur + 1'b1;
          end else if (found_q) st <= S_RATE;
          else begin
            st <= S_IDLE; done_q <= 1'b1;
          end
        end
        S_VCO: if (res_ok) begin
          wait_q <= 1'b0;
          if (accept) begin
            found_q <= 1'b1; b_n <= n_cur; b_m <= m_cur; b_vco <= dq; b_err <= err;
          end
          if (!last_n) begin
            n_cur <= n_cur + 1'b1; st <= S_MUL;
          end else if (found_q || accept) st <= S_RATE;
          else begin
            st <= S_IDLE; done_q <= 1'b1;
          end
        end
        S_RATE: if (res_ok) begin
          rate_q <= dq[FW-1:0]; wait_q <= 1'b0; st <= S_IDLE; done_q <= 1'b1;
        end
        default: st <= S_IDLE;
      endcase
    end
  end

  p_done_pulse_r1: assert property (@(posedge clk) disable iff (!rst_n) done |=> !done);
  p_done_idle_r1: assert property (@(posedge clk) disable iff (!rst_n) done |-> !busy);
  p_operands_held_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && $past(busy)) |-> ($stable(fref_q) && $stable(tgt_q)));
  p_div_count: assert property (@(posedge clk) disable iff (!rst_n) drun |-> cnt != '0);
  p_n_window_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (done && found) |-> (PW'(best_n) * PW'(PFD_MIN_KHZ) <= PW'(fref_q)
                         && PW'(best_n) * PW'(PFD_MAX_KHZ) >= PW'(fref_q)));
  p_m_even_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (done && found) |-> (!best_m[0] && best_m >= FW'(M_MIN) && best_m <= FW'(M_MAX)));
  p_vco_range_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (done && found) |-> (b_vco >= PW'(VCO_MIN_KHZ) && b_vco <= PW'(VCO_MAX_KHZ)));
  p_none_zero_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (done && !found) |-> (best_n == '0 && best_m == '0 && rate_mbps == '0));
  p_rate_ceil_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (done && found) |-> (PW'(rate_mbps) * PW'(RATE_UNIT_KHZ) >= b_vco
                         && (PW'(rate_mbps) - 1) * PW'(RATE_UNIT_KHZ) < b_vco));
  p_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && !start) |=> ($stable(best_n) && $stable(rate_mbps) && $stable(found)));
endmodule

// File: tb/pll_div_search_tb_top.sv
`timescale 1ns/1ps
module pll_div_search_tb_top;
  localparam int FW = 24;

  logic clk = 1'b0, rst_n = 1'b0, start = 1'b0;
  logic [FW-1:0] fref_khz = '0, target_khz = '0;
  logic busy, done, found;
  logic [FW-1:0] best_n, best_m, vco_khz, rate_mbps;

  int tests = 0, fails = 0;
  bit finished = 1'b0;

  always #4 clk = ~clk;

  pll_div_search #(.FW(FW)) dut_i (
    .clk(clk), .rst_n(rst_n), .start(start), .fref_khz(fref_khz), .target_khz(target_khz),
    .busy(busy), .done(done), .found(found), .best_n(best_n), .best_m(best_m),
    .vco_khz(vco_khz), .rate_mbps(rate_mbps));

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  longint e_n, e_m, e_vco, e_rate;
  bit e_found;

  task automatic model(input longint fr, input longint tg);
    longint lo, hi, be;
    e_found = 0; e_n = 0; e_m = 0; e_vco = 0; e_rate = 0; be = 0;
    lo = (fr + 39999) / 40000;
    if (lo == 0) lo = 1;
    hi = fr / 5000;
    for (longint n = lo; n <= hi; n++) begin
      longint m, v, er;
      m = tg * n / fr;
      if (m < 6 || m > 512) continue;
      m = m + (m % 2);
      v = m * fr / n;
      if (v < 80000 || v > 1500000) continue;
      er = (v > tg) ? v - tg : tg - v;
      if (!e_found || er < be) begin
        e_found = 1; e_n = n; e_m = m; e_vco = v; be = er;
      end
    end
    if (e_found) e_rate = (e_vco + 999) / 1000;
  endtask

  task automatic launch(input longint fr, input longint tg);
    @(negedge clk);
    fref_khz = FW'(fr); target_khz = FW'(tg); start = 1'b1;
    @(negedge clk);
    start = 1'b0;
  endtask

  task automatic wait_done(output bit ok);
    ok = 0;
    for (int i = 0; i < 5000; i++) begin
      if (done) begin ok = 1; break; end
      @(negedge clk);
    end
  endtask

  task automatic compare(input longint fr, input longint tg);
    chk(found == e_found, "R7 found", found, e_found);
    chk(best_n == FW'(e_n), "R2/R6 best_n", best_n, e_n);
    chk(best_m == FW'(e_m), "R3/R4 best_m", best_m, e_m);
    chk(vco_khz == FW'(e_vco), "R5 vco_khz", vco_khz, e_vco);
    chk(rate_mbps == FW'(e_rate), "R8 rate_mbps", rate_mbps, e_rate);
    if (found != e_found || best_n != FW'(e_n))
      $display("  case fref=%0d target=%0d", fr, tg);
  endtask

  task automatic run_case(input longint fr, input longint tg);
    bit ok;
    model(fr, tg);
    launch(fr, tg);
    chk(busy == 1'b1, "R1 busy after start", busy, 1);
    wait_done(ok);
    chk(ok, "R1 done reached", ok, 1);
    chk(!busy, "R1 busy low at done", busy, 0);
    compare(fr, tg);
    @(negedge clk);
    chk(!done, "R1 done one cycle", done, 0);
  endtask

  longint frs[7] = '{4000, 5000, 12000, 24000, 27000, 38400, 50000};
  longint tgs[11] = '{3000, 96000, 100000, 333333, 500000, 750000, 999000,
                      1200000, 1490000, 2000000, 3000000};

  initial begin
    bit ok;
    int extra;
    logic [FW-1:0] h_n, h_r;
    repeat (3) @(negedge clk);
    chk(!busy && !done && !found, "R9 flags in reset", {busy, done, found}, 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk(!busy && !done && !found, "R9 flags after reset", {busy, done, found}, 0);
    chk(best_n == 0 && best_m == 0 && rate_mbps == 0 && vco_khz == 0, "R9 results zero", rate_mbps, 0);

    foreach (frs[i]) foreach (tgs[j]) run_case(frs[i], tgs[j]);

    // R6 tie: fref 24000, target 96000 is hit exactly by N=2,3,4; smallest N kept
    run_case(24000, 96000);
    chk(best_n == 2, "R6 tie keeps smallest N", best_n, 2);
    // R3: M above 512 at the only N gives no result
    run_case(5000, 3000000);
    chk(!found, "R3 oversize M skipped", found, 0);

    // R1: disturbances while busy are ignored
    model(27000, 500000);
    launch(27000, 500000);
    repeat (3) @(negedge clk);
    fref_khz = FW'(50000); target_khz = FW'(1200000); start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    wait_done(ok);
    chk(ok, "R1 done after disturbed run", ok, 1);
    compare(27000, 500000);
    extra = 0;
    for (int k = 0; k < 40; k++) begin
      @(negedge clk);
      if (done) extra++;
    end
    chk(extra == 0, "R1 no extra done", extra, 0);

    // R10: results held while inputs move without start
    h_n = best_n; h_r = rate_mbps;
    fref_khz = FW'(12000); target_khz = FW'(96000);
    repeat (30) @(negedge clk);
    chk(best_n == h_n && rate_mbps == h_r && !busy, "R10 results held", best_n, h_n);

    finished = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    if (!finished) begin
      tests++; fails++;
      $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end
endmodule